// File: doc/BRIEF.md
# PCM Serial Sample Shifter

This block moves 16-bit signed audio samples across a DSP-style PCM serial link. It does not make its own bit clock. A clock generator supplies two single-cycle strobes in the system clock domain: a launch strobe, where transmit data changes, and a sample strobe, where receive data is captured. The generator also supplies a frame sync level, which is valid alongside the launch strobe and is high for exactly one bit period per frame. Words move MSB first.

Transmit words come from a FIFO through a valid/ready handshake. One word is taken at the start of each frame. Received words go to a FIFO as a 17-bit value whose top bit is a valid flag. Transmit and receive each have their own enable, and a global enable must also be set. Each direction also has its own choice of MSB placement: either in the same bit period as the sync pulse (early), or in the bit period after it (late). If no transmit word is ready at frame start, the frame is sent as zeros and a starve pulse is raised. If a received word cannot be handed over, it is dropped and an overflow pulse is raised.

Top module: `pcm_shifter`

## Requirements
- R1: With `tx_late`=0, the transmit word appears on `sdo` MSB first. Bit 15 is driven in the sync bit period, and bit 15-k is driven k bit periods later.
- R2: With `tx_late`=1, `sdo` is 0 during the sync bit period. Bit 15 is driven in the next bit period, and bit 15-k is driven k+1 bit periods after sync.
- R3: The receiver captures `sdi` at sample strobes. It takes bit 15 in the sync bit period when `rx_late`=0, or in the period after it when `rx_late`=1, independent of `tx_late`.
- R4: Bit periods outside the 16-bit window of a frame carry 0 on `sdo`, and `sdi` values in those periods have no effect on the received word.
- R5: A direction is active only while its own enable and `glb_en` are both 1. An inactive transmitter drives `sdo`=0 from its next launch strobe, never asserts `tx_ready`, and never asserts `tx_starve`. An inactive receiver delivers no word and never asserts `rx_ovf`.
- R6: `tx_ready` is 1 only in a cycle with `launch_stb`=1 and `fsync`=1 while transmit is active. The word on `tx_data` is consumed when `tx_valid` is also 1.
- R7: If `tx_valid` is 0 at an active frame start, the frame sends all zeros and `tx_starve` pulses high for one cycle, in the cycle after that frame start.
- R8: A completed receive word is presented as `rx_word[16]`=1 (the same value as `rx_valid`) with the data in `rx_word[15:0]`. It is held unchanged until a cycle with `rx_ready`=1, after which `rx_valid` is 0.
- R9: If a word completes while the previous word is still valid and `rx_ready`=0, the new word is dropped, `rx_word` keeps its value, and `rx_ovf` pulses for one cycle.
- R10: While `rst` is high and just after it, `sdo`, `tx_ready`, `tx_starve`, `rx_valid` and `rx_ovf` are 0.
- R11: `sdo` changes only in the cycle after a launch strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_late | input | 1 | Transmit MSB one bit after sync when 1 |
| rx_late | input | 1 | Receive MSB one bit after sync when 1 |
| launch_stb | input | 1 | One-cycle strobe at the bit-clock launch edge |
| sample_stb | input | 1 | One-cycle strobe at the bit-clock sample edge |
| fsync | input | 1 | Frame sync level, valid with launch_stb |
| tx_data | input | 16 | Transmit sample from FIFO |
| tx_valid | input | 1 | Transmit sample available |
| tx_ready | output | 1 | Transmit sample taken this cycle |
| sdo | output | 1 | Serial data out |
| tx_starve | output | 1 | One-cycle pulse: frame started without a sample |
| sdi | input | 1 | Serial data in |
| rx_word | output | 17 | Valid flag in bit 16, received sample in bits 15:0 |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Downstream accepts the received word |
| rx_ovf | output | 1 | One-cycle pulse: received word dropped |

## Verification
Frame alignment can be off by one bit period if the remaining-bit counter or the receive position counter is wrong. That error moves every bit of the word by one place. It shows as a wrong reassembled word in the first frame, and as nonzero bits outside the 16-bit window. A fault in the handshake or the valid flag shows within one frame: a word count that differs from the number of frames, a lost word, or an overflow pulse where none should occur. The sweep runs every combination of the two MSB placements with several sample patterns. Between the windows it drives ones on `sdi`, so that a receive window that is too wide changes the word.

// File: rtl/pcm_shifter_pkg.sv
package pcm_shifter_pkg;
  localparam int DEF_SAMPLE_W = 16;
  localparam int DEF_POS_W    = 6;
endpackage

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int SAMPLE_W = pcm_shifter_pkg::DEF_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic                late,
  input  logic                launch_stb,
  input  logic                fsync,
  input  logic [SAMPLE_W-1:0] data_in,
  input  logic                data_valid,
  output logic                data_take,
  output logic                sdo,
  output logic                starve
);
  localparam int REM_W = $clog2(SAMPLE_W + 1);

  logic [SAMPLE_W-1:0] shreg;
  logic [REM_W-1:0]    remain;
  logic [SAMPLE_W-1:0] frame_word;

  assign data_take  = active & launch_stb & fsync;
  assign frame_word = data_valid ? data_in : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo    <= 1'b0;
      shreg  <= '0;
      remain <= '0;
      starve <= 1'b0;
    end else begin
      starve <= 1'b0;
      if (launch_stb) begin
        if (!active) begin
          sdo    <= 1'b0;
          remain <= '0;
        end else if (fsync) begin
          starve <= !data_valid;
          if (late) begin
            sdo    <= 1'b0;
            shreg  <= frame_word;
            remain <= REM_W'(SAMPLE_W);
          end else begin
            sdo    <= frame_word[SAMPLE_W-1];
            shreg  <= {frame_word[SAMPLE_W-2:0], 1'b0};
            remain <= REM_W'(SAMPLE_W - 1);
          end
        end else if (remain != '0) begin
          sdo    <= shreg[SAMPLE_W-1];
          shreg  <= {shreg[SAMPLE_W-2:0], 1'b0};
          remain <= remain - 1'b1;
        end else begin
          sdo <= 1'b0;
        end
      end
    end
  end

  // R11: serial output moves only after a launch strobe
  p_sdo_on_launch_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(launch_stb) |-> $stable(sdo));

  // R5: an inactive lane goes quiet at its launch strobe
  p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (rst)
    $past(launch_stb && !active) |-> (sdo == 1'b0));

  // R7: starve follows a frame start of an active lane
  p_starve_at_frame_r7: assert property (@(posedge clk) disable iff (rst)
    starve |-> $past(launch_stb && fsync && active && !data_valid));
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
  parameter int SAMPLE_W = pcm_shifter_pkg::DEF_SAMPLE_W,
  parameter int POS_W    = pcm_shifter_pkg::DEF_POS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              late,
  input  logic              launch_stb,
  input  logic              sample_stb,
  input  logic              fsync,
  input  logic              sdi,
  input  logic              word_ready,
  output logic [SAMPLE_W:0] word_out,
  output logic              ovf
);
  localparam logic [POS_W-1:0] WIN_LEN = POS_W'(SAMPLE_W);

  logic                sync_period;
  logic [POS_W-1:0]    pos_q;
  logic [POS_W-1:0]    pos_now;
  logic [POS_W-1:0]    win_lo;
  logic                in_window;
  logic                last_bit;
  logic [SAMPLE_W-1:0] shreg;

  always_comb begin
    pos_now   = sync_period ? '0 : pos_q;
    win_lo    = POS_W'(late);
    in_window = (pos_now >= win_lo) && (pos_now < win_lo + WIN_LEN);
    last_bit  = (pos_now == win_lo + WIN_LEN - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_period <= 1'b0;
      pos_q       <= '1;
      shreg       <= '0;
      word_out    <= '0;
      ovf         <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (launch_stb) sync_period <= fsync;
      if (word_out[SAMPLE_W] && word_ready) word_out[SAMPLE_W] <= 1'b0;
      if (sample_stb) begin
        pos_q <= (pos_now == '1) ? pos_now : pos_now + 1'b1;
        if (active && in_window) begin
          shreg <= {shreg[SAMPLE_W-2:0], sdi};
          if (last_bit) begin
            if (word_out[SAMPLE_W] && !word_ready) ovf <= 1'b1;
            else word_out <= {1'b1, shreg[SAMPLE_W-2:0], sdi};
          end
        end
      end
    end
  end

  // R8: an unaccepted word stays put
  p_valid_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (word_out[SAMPLE_W] && !word_ready) |=> (word_out[SAMPLE_W] && $stable(word_out)));

  // R9: overflow leaves the presented word untouched
  p_no_overwrite_r9: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (word_out[SAMPLE_W] && $stable(word_out)));

  // R5: no overflow from an inactive receiver
  p_ovf_only_active_r5: assert property (@(posedge clk) disable iff (rst)
    ovf |-> $past(active));
endmodule

// File: rtl/pcm_shifter.sv
module pcm_shifter #(
  parameter int SAMPLE_W = pcm_shifter_pkg::DEF_SAMPLE_W,
  parameter int POS_W    = pcm_shifter_pkg::DEF_POS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_late,
  input  logic              rx_late,
  input  logic              launch_stb,
  input  logic              sample_stb,
  input  logic              fsync,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              sdo,
  output logic              tx_starve,
  input  logic              sdi,
  output logic [SAMPLE_W:0] rx_word,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_ovf
);
  logic tx_active;
  logic rx_active;

  assign tx_active = glb_en & tx_en;
  assign rx_active = glb_en & rx_en;

  pcm_tx_lane #(.SAMPLE_W(SAMPLE_W)) tx_lane_i (
    .clk        (clk),
    .rst        (rst),
    .active     (tx_active),
    .late       (tx_late),
    .launch_stb (launch_stb),
    .fsync      (fsync),
    .data_in    (tx_data),
    .data_valid (tx_valid),
    .data_take  (tx_ready),
    .sdo        (sdo),
    .starve     (tx_starve)
  );

  pcm_rx_lane #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) rx_lane_i (
    .clk        (clk),
    .rst        (rst),
    .active     (rx_active),
    .late       (rx_late),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb),
    .fsync      (fsync),
    .sdi        (sdi),
    .word_ready (rx_ready),
    .word_out   (rx_word),
    .ovf        (rx_ovf)
  );

  assign rx_valid = rx_word[SAMPLE_W];

  // R6: a take never happens on an idle transmitter or outside a frame start
  p_take_at_sync_r6: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (glb_en && tx_en && fsync && launch_stb));
endmodule

// File: tb/pcm_shifter_tb_top.sv
module pcm_shifter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FB         = 20;
  localparam int WD_LIMIT   = 100000;

  logic clk = 1'b0;
  logic rst;
  logic glb_en, tx_en, rx_en, tx_late, rx_late;
  logic launch_stb, sample_stb, fsync;
  logic [15:0] tx_data;
  logic tx_valid, tx_ready, sdo, tx_starve, sdi;
  logic [16:0] rx_word;
  logic rx_valid, rx_ready, rx_ovf;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int pops = 0, starves = 0, ovfs = 0, rx_cnt = 0;
  logic [16:0] last_rx = '0;
  logic [15:0] tx_got;
  logic        tx_extra;
  logic [15:0] cur_rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_shifter dut_i (
    .clk(clk), .rst(rst), .glb_en(glb_en), .tx_en(tx_en), .rx_en(rx_en),
    .tx_late(tx_late), .rx_late(rx_late), .launch_stb(launch_stb),
    .sample_stb(sample_stb), .fsync(fsync), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .sdo(sdo),
    .tx_starve(tx_starve), .sdi(sdi), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ovf(rx_ovf)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && tx_ready) pops <= pops + 1;
    if (tx_starve) starves <= starves + 1;
    if (rx_ovf) ovfs <= ovfs + 1;
    if (rx_valid && rx_ready) begin
      rx_cnt  <= rx_cnt + 1;
      last_rx <= rx_word;
    end
    if (cyc > WD_LIMIT) begin
      fails = fails + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic rx_bit(input int b);
    int d;
    d = b - int'(rx_late);
    if (d >= 0 && d < 16) return cur_rx[15-d];
    return 1'b1;
  endfunction

  task automatic run_frame(input bit have, input logic [15:0] txw, input logic [15:0] rxw);
    cur_rx   = rxw;
    tx_got   = '0;
    tx_extra = 1'b0;
    for (int b = 0; b < FB; b++) begin
      @(negedge clk);
      launch_stb = 1'b1;
      fsync      = (b == 0);
      sdi        = rx_bit(b);
      if (b == 0) begin
        tx_valid = have;
        tx_data  = txw;
      end
      @(negedge clk);
      launch_stb = 1'b0;
      fsync      = 1'b0;
      tx_valid   = 1'b0;
      @(negedge clk);
      sample_stb = 1'b1;
      begin
        int d;
        d = b - int'(tx_late);
        if (d >= 0 && d < 16) tx_got[15-d] = sdo;
        else if (sdo) tx_extra = 1'b1;
      end
      @(negedge clk);
      sample_stb = 1'b0;
    end
  endtask

  initial begin
    rst = 1'b1; glb_en = 1'b0; tx_en = 1'b0; rx_en = 1'b0;
    tx_late = 1'b0; rx_late = 1'b0; launch_stb = 1'b0; sample_stb = 1'b0;
    fsync = 1'b0; tx_data = '0; tx_valid = 1'b0; sdi = 1'b0; rx_ready = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    check({sdo, tx_ready, tx_starve, rx_valid, rx_ovf} == 5'b0, "R10",
          {27'b0, sdo, tx_ready, tx_starve, rx_valid, rx_ovf}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check({sdo, tx_starve, rx_valid, rx_ovf} == 4'b0, "R10 after release",
          {28'b0, sdo, tx_starve, rx_valid, rx_ovf}, 32'h0);
    glb_en = 1'b1; tx_en = 1'b1; rx_en = 1'b1;

    // Sweep of all MSB placements with several patterns (R1 R2 R3 R4 R6 R8)
    for (int m = 0; m < 4; m++) begin
      tx_late = m[0];
      rx_late = m[1];
      for (int k = 0; k < 6; k++) begin
        logic [15:0] tw, rw;
        int p0, r0;
        tw = (k == 0) ? 16'h8000 : (k == 1) ? 16'h0001 : 16'(k * 16'h1357 + m * 16'h2468);
        rw = ~tw ^ 16'(k * 16'h0F0F);
        p0 = pops; r0 = rx_cnt;
        run_frame(1'b1, tw, rw);
        check(tx_got == tw, tx_late ? "R2 tx word" : "R1 tx word", {16'b0, tx_got}, {16'b0, tw});
        check(!tx_extra, "R4 tx outside window", {31'b0, tx_extra}, 32'h0);
        check(rx_cnt == r0 + 1 && last_rx == {1'b1, rw}, "R3 R4 R8 rx word",
              {15'b0, last_rx}, {15'b0, 1'b1, rw});
        check(pops == p0 + 1, "R6 one take per frame", pops - p0, 32'h1);
      end
    end

    // R7: starve frame
    tx_late = 1'b0; rx_late = 1'b0;
    begin
      int s0;
      s0 = starves;
      run_frame(1'b0, 16'hFFFF, 16'h1234);
      check(tx_got == 16'h0 && !tx_extra, "R7 zeros on starve", {16'b0, tx_got}, 32'h0);
      check(starves == s0 + 1, "R7 starve pulse", starves - s0, 32'h1);
    end

    // R5: transmit disabled
    begin
      int s0, p0;
      s0 = starves; p0 = pops;
      tx_en = 1'b0;
      run_frame(1'b1, 16'hBEEF, 16'h4321);
      check(tx_got == 16'h0 && !tx_extra, "R5 tx off sdo", {16'b0, tx_got}, 32'h0);
      check(pops == p0, "R5 tx off no take", pops - p0, 32'h0);
      run_frame(1'b0, 16'h0, 16'h4321);
      check(starves == s0, "R5 tx off no starve", starves - s0, 32'h0);
      tx_en = 1'b1;
    end

    // R5: receive disabled, then global disable
    begin
      int r0, p0;
      r0 = rx_cnt;
      rx_en = 1'b0;
      run_frame(1'b1, 16'h1111, 16'hCAFE);
      check(rx_cnt == r0 && !rx_valid, "R5 rx off no word", rx_cnt - r0, 32'h0);
      rx_en = 1'b1;
      glb_en = 1'b0;
      r0 = rx_cnt; p0 = pops;
      run_frame(1'b1, 16'h2222, 16'hD00D);
      check(rx_cnt == r0 && pops == p0 && tx_got == 16'h0, "R5 global off",
            rx_cnt - r0 + pops - p0, 32'h0);
      glb_en = 1'b1;
      run_frame(1'b1, 16'h3C3C, 16'h5A5A);
      check(tx_got == 16'h3C3C && last_rx == {1'b1, 16'h5A5A}, "R5 re-enable",
            {15'b0, last_rx}, {15'b0, 17'h15A5A});
    end

    // R9: overflow drops the newer word
    begin
      int o0, r0;
      o0 = ovfs; r0 = rx_cnt;
      rx_ready = 1'b0;
      run_frame(1'b1, 16'h0F0F, 16'h9ABC);
      check(rx_valid && rx_word == {1'b1, 16'h9ABC}, "R8 held word", {15'b0, rx_word}, {15'b0, 17'h19ABC});
      run_frame(1'b1, 16'h0F0F, 16'h7777);
      check(ovfs == o0 + 1, "R9 overflow pulse", ovfs - o0, 32'h1);
      check(rx_word == {1'b1, 16'h9ABC}, "R9 word kept", {15'b0, rx_word}, {15'b0, 17'h19ABC});
      rx_ready = 1'b1;
      @(negedge clk);
      check(rx_cnt == r0 + 1 && last_rx == {1'b1, 16'h9ABC}, "R8 delivered after ready",
            {15'b0, last_rx}, {15'b0, 17'h19ABC});
      check(!rx_valid, "R8 valid clears", {31'b0, rx_valid}, 32'h0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule